// File: doc/BRIEF.md
# First-Come Shared Lane Bus

This block models a wide internal shared bus as a multiplexer instead of tristate wires. Several requesters each offer a full-width data word and one drive-enable per 9-bit lane, where a lane is eight data bits plus a parity bit. The twelve lanes, 108 lines in total, are gathered into groups by a mode input. Each group is arbitrated on its own. The first requester to enable on an idle group becomes its owner and keeps it for as long as it holds an enable anywhere in that group. An undriven lane keeps the last value driven onto it.

Per-lane owner and valid outputs show which requester holds the group that each lane belongs to. A surrounding design, or a bench, can use them to confirm that a group has exactly one driver. Parity is carried through untouched: the block neither generates nor checks it.

Top module: `laneShareBus`

## Requirements
- R1: During and right after reset every lane reads zero, every lane valid is low and every lane owner reads zero.
- R2: When requesters enable on an idle group, the lowest-indexed one becomes owner at the next clock edge. While a lane's group has no owner, its owner output reads zero.
- R3: While the owner keeps any enable set within its group, the group stays valid with the same owner, whatever the other requesters assert.
- R4: A lane whose group owner has that lane's enable set shows all 9 of the owner's bits, parity included, in the same cycle.
- R5: When the owner clears all its enables in the group, valid drops at the next edge. A requester still enabling is granted at the edge after that, so there is one idle cycle.
- R6: A lane that is not being driven by its owner shows the last value that was driven onto it.
- R7: Mode encoding: 0 gives twelve 1-lane groups (group g is lane g); 1 gives six 2-lane groups (lanes 2g and 2g+1); 2 gives three 4-lane groups (lanes 4g to 4g+3); 3 acts as 0. A requester requests a group when any of its enables within the group is set.
- R8: The mode input is taken only at an edge where every group is idle. Otherwise the previous grouping stays in force.
- R9: Inside an owned group, a lane whose owner enable is low holds its value while the other lanes of the group are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grpMode | input | 2 | Lane grouping request (R7 encoding) |
| reqEn | input | NUM_REQ*12 | Enable of requester r on lane l at bit r*12+l |
| reqData | input | NUM_REQ*108 | Data of requester r on lane l at bits r*108+l*9 +: 9, bit 8 is parity |
| busOut | output | 108 | Bus value, lane l at bits l*9 +: 9 |
| laneValid | output | 12 | Group of lane l has an owner |
| laneOwner | output | 48 | Owner index of lane l at bits l*4 +: 4 |

## Verification
The hardest situation to reach is a change of grouping. The mode is taken only when all twelve lanes are idle at once, and random enables almost never leave every group free together. The random stimulus therefore pulls every enable low for a few cycles at regular intervals and presents a new mode during that window. Directed steps cover the opposite case, a mode request made while a group is busy, and show that lanes keep their old grouping until the bus drains.

// File: rtl/laneShareBus_pkg.sv
package laneShareBus_pkg;
  localparam int LANE_W    = 9;
  localparam int NUM_LANES = 12;
  localparam int IDX_W     = 4;
  localparam int MAX_SPAN  = 4;
  localparam int BUS_W     = LANE_W * NUM_LANES;

  typedef enum logic [1:0] {
    GRP_SINGLE = 2'd0,
    GRP_PAIR   = 2'd1,
    GRP_QUAD   = 2'd2,
    GRP_ALIAS  = 2'd3
  } grpMode_e;

  typedef struct packed {
    logic [NUM_LANES-1:0]            laneDrive;
    logic [NUM_LANES-1:0][IDX_W-1:0] laneSel;
  } laneStrobe_t;

  function automatic logic [1:0] cleanMode(input logic [1:0] m);
    return (m == GRP_ALIAS) ? GRP_SINGLE : m;
  endfunction

  function automatic int spanOf(input logic [1:0] m);
    case (m)
      GRP_PAIR: return 2;
      GRP_QUAD: return 4;
      default:  return 1;
    endcase
  endfunction
endpackage

// File: rtl/reqPick.sv
module reqPick #(
  parameter int N = 4,
  parameter int W = 4
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/laneArbCtrl.sv
module laneArbCtrl
  import laneShareBus_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [1:0]                            grpModeIn,
  input  logic [NUM_REQ-1:0][NUM_LANES-1:0]     enArr,
  output laneStrobe_t                           strobes,
  output logic [NUM_LANES-1:0]                  laneValidOut,
  output logic [NUM_LANES-1:0][IDX_W-1:0]       laneOwnerOut,
  output logic [1:0]                            curMode
);
  logic [NUM_LANES-1:0]             grpValid;
  logic [NUM_LANES-1:0][IDX_W-1:0]  grpOwner;
  logic [1:0]                       modeReg;
  logic [1:0]                       modeEff;
  logic                             allIdle;
  logic [NUM_LANES-1:0][NUM_REQ-1:0] groupReq;
  logic [NUM_LANES-1:0]             ownReq;
  logic [NUM_LANES-1:0]             pickAny;
  logic [NUM_LANES-1:0][IDX_W-1:0]  pickIdx;

  assign allIdle = ~|grpValid;
  assign modeEff = allIdle ? cleanMode(grpModeIn) : modeReg;
  assign curMode = modeReg;

  // Per-group request vectors under the grouping in force at this edge.
  always_comb begin
    int spanEff;
    int idx;
    spanEff = spanOf(modeEff);
    for (int g = 0; g < NUM_LANES; g++) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        groupReq[g][r] = 1'b0;
        for (int k = 0; k < MAX_SPAN; k++) begin
          idx = g * spanEff + k;
          if (k < spanEff && idx < NUM_LANES) begin
            groupReq[g][r] = groupReq[g][r] | enArr[r][idx];
          end
        end
      end
    end
  end

  always_comb begin
    for (int g = 0; g < NUM_LANES; g++) begin
      ownReq[g] = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        if (grpOwner[g] == IDX_W'(r)) ownReq[g] = groupReq[g][r];
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : gPick
      reqPick #(.N(NUM_REQ), .W(IDX_W)) uPick (
        .req (groupReq[g]),
        .any (pickAny[g]),
        .idx (pickIdx[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpValid <= '0;
      grpOwner <= '0;
      modeReg  <= GRP_SINGLE;
    end else begin
      modeReg <= modeEff;
      for (int g = 0; g < NUM_LANES; g++) begin
        if (grpValid[g]) begin
          if (!ownReq[g]) begin
            grpValid[g] <= 1'b0;
            grpOwner[g] <= '0;
          end
        end else if (pickAny[g]) begin
          grpValid[g] <= 1'b1;
          grpOwner[g] <= pickIdx[g];
        end
      end
    end
  end

  // Map group state onto lanes using the registered grouping.
  always_comb begin
    int g;
    logic ownEn;
    for (int l = 0; l < NUM_LANES; l++) begin
      case (modeReg)
        GRP_PAIR: g = l >> 1;
        GRP_QUAD: g = l >> 2;
        default:  g = l;
      endcase
      ownEn = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        if (grpOwner[g] == IDX_W'(r)) ownEn = enArr[r][l];
      end
      laneValidOut[l]      = grpValid[g];
      laneOwnerOut[l]      = grpOwner[g];
      strobes.laneSel[l]   = grpOwner[g];
      strobes.laneDrive[l] = grpValid[g] & ownEn;
    end
  end
endmodule

// File: rtl/laneDatapath.sv
module laneDatapath
  import laneShareBus_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic [NUM_REQ-1:0][NUM_LANES-1:0][LANE_W-1:0] dataArr,
  input  laneStrobe_t                                 strobes,
  output logic [NUM_LANES-1:0][LANE_W-1:0]            busArr
);
  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : gLane
      logic [LANE_W-1:0] holdReg;
      logic [LANE_W-1:0] picked;

      always_comb begin
        picked = '0;
        for (int r = 0; r < NUM_REQ; r++) begin
          if (strobes.laneSel[l] == IDX_W'(r)) picked = dataArr[r][l];
        end
      end

      assign busArr[l] = strobes.laneDrive[l] ? picked : holdReg;

      always_ff @(posedge clk) begin
        if (!rstN) holdReg <= '0;
        else       holdReg <= busArr[l];
      end
    end
  endgenerate
endmodule

// File: rtl/laneShareBus.sv
module laneShareBus
  import laneShareBus_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [1:0]                     grpMode,
  input  logic [NUM_REQ*NUM_LANES-1:0]   reqEn,
  input  logic [NUM_REQ*BUS_W-1:0]       reqData,
  output logic [BUS_W-1:0]               busOut,
  output logic [NUM_LANES-1:0]           laneValid,
  output logic [NUM_LANES*IDX_W-1:0]     laneOwner
);
  logic [NUM_REQ-1:0][NUM_LANES-1:0]               enArr;
  logic [NUM_REQ-1:0][NUM_LANES-1:0][LANE_W-1:0]   dataArr;
  logic [NUM_LANES-1:0][LANE_W-1:0]                busArr;
  logic [NUM_LANES-1:0][IDX_W-1:0]                 ownerArr;
  laneStrobe_t                                     strobes;
  logic [1:0]                                      curMode;

  assign enArr     = reqEn;
  assign dataArr   = reqData;
  assign busOut    = busArr;
  assign laneOwner = ownerArr;

  laneArbCtrl #(.NUM_REQ(NUM_REQ)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .grpModeIn    (grpMode),
    .enArr        (enArr),
    .strobes      (strobes),
    .laneValidOut (laneValid),
    .laneOwnerOut (ownerArr),
    .curMode      (curMode)
  );

  laneDatapath #(.NUM_REQ(NUM_REQ)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .dataArr (dataArr),
    .strobes (strobes),
    .busArr  (busArr)
  );
endmodule

// File: rtl/laneShareChk.sv
module laneShareChk
  import laneShareBus_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_REQ*NUM_LANES-1:0] reqEn,
  input logic [BUS_W-1:0]             busOut,
  input logic [NUM_LANES-1:0]         laneValid,
  input logic [NUM_LANES*IDX_W-1:0]   laneOwner,
  input logic [1:0]                   curMode
);
  logic [NUM_LANES-1:0] ownEnLane;
  logic [NUM_LANES-1:0] ownGrpReq;

  always_comb begin
    int sh;
    case (curMode)
      2'd1:    sh = 1;
      2'd2:    sh = 2;
      default: sh = 0;
    endcase
    for (int l = 0; l < NUM_LANES; l++) begin
      ownEnLane[l] = 1'b0;
      ownGrpReq[l] = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        if (laneOwner[l*IDX_W +: IDX_W] == IDX_W'(r)) begin
          ownEnLane[l] = reqEn[r*NUM_LANES + l];
          for (int m = 0; m < NUM_LANES; m++) begin
            if ((m >> sh) == (l >> sh))
              ownGrpReq[l] = ownGrpReq[l] | reqEn[r*NUM_LANES + m];
          end
        end
      end
    end
  end

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    curMode != 2'd3); // R7
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (|laneValid) |=> $stable(curMode)); // R8

  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : gLaneChk
      AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rstN)
        laneValid[l] |=> (!laneValid[l] ||
          laneOwner[l*IDX_W +: IDX_W] == $past(laneOwner[l*IDX_W +: IDX_W]))); // R3
      AST_OWNER_STAYS: assert property (@(posedge clk) disable iff (!rstN)
        (laneValid[l] && ownGrpReq[l]) |=> laneValid[l]); // R3
      AST_RELEASE_DROP: assert property (@(posedge clk) disable iff (!rstN)
        (laneValid[l] && !ownGrpReq[l]) |=> !laneValid[l]); // R5
      AST_IDLE_OWNER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        !laneValid[l] |-> laneOwner[l*IDX_W +: IDX_W] == '0); // R2
      AST_HOLD_LAST: assert property (@(posedge clk) disable iff (!rstN)
        !(laneValid[l] && ownEnLane[l]) |->
          busOut[l*LANE_W +: LANE_W] == $past(busOut[l*LANE_W +: LANE_W])); // R6
    end
  endgenerate
endmodule

bind laneShareBus laneShareChk #(.NUM_REQ(NUM_REQ)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqEn     (reqEn),
  .busOut    (busOut),
  .laneValid (laneValid),
  .laneOwner (laneOwner),
  .curMode   (curMode)
);

// File: tb/tb_laneShareBus.sv
module tb_laneShareBus;
  localparam int NR = 4;
  localparam int NL = 12;
  localparam int LW = 9;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] grpMode = 2'd0;
  logic [NR*NL-1:0] reqEn;
  logic [NR*NL*LW-1:0] reqData;
  logic [NL*LW-1:0] busOut;
  logic [NL-1:0] laneValid;
  logic [NL*IW-1:0] laneOwner;

  logic       en  [NR][NL];
  logic [8:0] dat [NR][NL];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state built from the requirements
  logic       mValid [NL];
  int         mOwner [NL];
  logic [8:0] mHold  [NL];
  int         mMode;
  logic [8:0] eBus [NL];
  logic       eVal [NL];
  int         eOwn [NL];

  always #4 clk = ~clk;

  always_comb begin
    for (int r = 0; r < NR; r++)
      for (int l = 0; l < NL; l++) begin
        reqEn[r*NL + l]              = en[r][l];
        reqData[(r*NL + l)*LW +: LW] = dat[r][l];
      end
  end

  laneShareBus #(.NUM_REQ(NR)) dut (
    .clk(clk), .rstN(rstN), .grpMode(grpMode), .reqEn(reqEn),
    .reqData(reqData), .busOut(busOut), .laneValid(laneValid),
    .laneOwner(laneOwner)
  );

  function automatic int spanFor(int m);
    return (m == 1) ? 2 : ((m == 2) ? 4 : 1);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void predict();
    int s, g;
    s = spanFor(mMode);
    for (int l = 0; l < NL; l++) begin
      g = l / s;
      eVal[l] = mValid[g];
      eOwn[l] = mValid[g] ? mOwner[g] : 0;
      eBus[l] = (mValid[g] && en[mOwner[g]][l]) ? dat[mOwner[g]][l] : mHold[l];
    end
  endfunction

  function automatic void advance();
    bit idle;
    int eff, s;
    bit req [NR];
    idle = 1;
    for (int g = 0; g < NL; g++) if (mValid[g]) idle = 0;
    eff = idle ? ((grpMode == 2'd3) ? 0 : int'(grpMode)) : mMode;
    s = spanFor(eff);
    for (int g = 0; g < NL; g++) begin
      if (g * s < NL) begin
        for (int r = 0; r < NR; r++) begin
          req[r] = 0;
          for (int k = 0; k < s; k++) if (en[r][g*s + k]) req[r] = 1;
        end
        if (mValid[g]) begin
          if (!req[mOwner[g]]) begin mValid[g] = 0; mOwner[g] = 0; end
        end else begin
          for (int r = NR - 1; r >= 0; r--)
            if (req[r]) begin mValid[g] = 1; mOwner[g] = r; end
        end
      end
    end
    for (int l = 0; l < NL; l++) mHold[l] = eBus[l];
    mMode = eff;
  endfunction

  // Called just after a falling edge with inputs already set.
  task automatic step(string req);
    logic [NL*LW-1:0] expBus;
    logic [NL-1:0]    expVal;
    logic [NL*IW-1:0] expOwn;
    #1;
    predict();
    for (int l = 0; l < NL; l++) begin
      expBus[l*LW +: LW] = eBus[l];
      expVal[l]          = eVal[l];
      expOwn[l*IW +: IW] = IW'(eOwn[l]);
    end
    chk(busOut == expBus, req, "busOut", 64'(busOut), 64'(expBus));
    chk(laneValid == expVal, req, "laneValid", 64'(laneValid), 64'(expVal));
    chk(laneOwner == expOwn, req, "laneOwner", 64'(laneOwner), 64'(expOwn));
    @(posedge clk);
    advance();
    @(negedge clk);
  endtask

  task automatic clearEn();
    for (int r = 0; r < NR; r++) for (int l = 0; l < NL; l++) en[r][l] = 0;
  endtask

  function automatic logic [8:0] laneBus(int l);
    return busOut[l*LW +: LW];
  endfunction
  function automatic logic [3:0] laneOwn(int l);
    return laneOwner[l*IW +: IW];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired before the run finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    clearEn();
    for (int r = 0; r < NR; r++)
      for (int l = 0; l < NL; l++) dat[r][l] = 9'((r * 37 + l * 11) & 9'h1FF);
    for (int g = 0; g < NL; g++) begin mValid[g] = 0; mOwner[g] = 0; mHold[g] = '0; end
    mMode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(busOut == '0, "R1", "busOut", 64'(busOut), 64'd0);
    chk(laneValid == '0, "R1", "laneValid", 64'(laneValid), 64'd0);
    chk(laneOwner == '0, "R1", "laneOwner", 64'(laneOwner), 64'd0);
    rstN = 1'b1;

    // R2: simultaneous requests on idle lane 0, lowest index wins
    dat[1][0] = 9'h1A5;
    dat[2][0] = 9'h0C3;
    en[2][0] = 1; en[1][0] = 1;
    step("R2");
    step("R2");
    chk(laneOwn(0) == 4'd1, "R2", "owner lane0", 64'(laneOwn(0)), 64'd1);
    chk(laneBus(0) == 9'h1A5, "R4", "lane0 with parity", 64'(laneBus(0)), 64'h1A5);

    // R3: a lower requester arrives late and is ignored
    en[0][0] = 1;
    step("R3");
    step("R3");
    chk(laneOwn(0) == 4'd1, "R3", "owner kept", 64'(laneOwn(0)), 64'd1);

    // R5 / R6: owner releases, one idle cycle, then lowest waiter
    en[1][0] = 0;
    #1;
    chk(laneBus(0) == 9'h1A5, "R6", "lane0 held on release", 64'(laneBus(0)), 64'h1A5);
    step("R5");
    chk(laneValid[0] == 1'b0, "R5", "idle cycle", 64'(laneValid[0]), 64'd0);
    step("R5");
    chk(laneOwn(0) == 4'd0 && laneValid[0], "R5", "regrant to 0", 64'(laneOwn(0)), 64'd0);
    dat[0][0] = 9'h155;
    step("R4");
    clearEn();
    step("R6");
    step("R6");
    chk(laneBus(0) == 9'h155, "R6", "lane0 last driven", 64'(laneBus(0)), 64'h155);

    // R8: mode request while busy is deferred
    en[3][5] = 1;
    step("R8");
    grpMode = 2'd1;
    en[2][4] = 1;
    step("R8");
    step("R8");
    chk(laneOwn(4) == 4'd2 && laneOwn(5) == 4'd3, "R8", "lanes 4,5 still separate",
        64'({laneOwn(4), laneOwn(5)}), 64'h23);
    clearEn();
    step("R8");
    step("R8");

    // R7 / R9: pair mode, requester 1 enables only lane 3 of group 1
    en[1][3] = 1;
    dat[1][3] = 9'h1F0;
    step("R7");
    step("R9");
    chk(laneValid[2] && laneOwn(2) == 4'd1, "R7", "lane2 joins pair group",
        64'(laneOwn(2)), 64'd1);
    chk(laneBus(3) == 9'h1F0, "R9", "lane3 driven", 64'(laneBus(3)), 64'h1F0);
    step("R9");

    // R7: quad mode
    clearEn();
    step("R7");
    grpMode = 2'd2;
    step("R7");
    en[3][11] = 1; en[2][8] = 1;
    step("R7");
    step("R7");
    chk(laneOwn(11) == 4'd2, "R7", "quad group owner", 64'(laneOwn(11)), 64'd2);

    // R7: mode 3 behaves as single lanes
    clearEn();
    step("R7");
    step("R7");
    grpMode = 2'd3;
    step("R7");
    en[1][7] = 1;
    step("R7");
    step("R7");
    chk(laneValid[6] == 1'b0 && laneValid[7], "R7", "alias mode single lanes",
        64'(laneValid[7:6]), 64'h2);

    // Random phase: R3 R4 R5 R6 R8
    for (int c = 0; c < 3000; c++) begin
      if (c % 200 < 3) begin
        clearEn();
        if (c % 200 == 2) grpMode = 2'($urandom_range(0, 3));
      end else begin
        for (int r = 0; r < NR; r++)
          for (int l = 0; l < NL; l++) begin
            if ($urandom_range(0, 5) == 0) en[r][l] = ~en[r][l];
            dat[r][l] = 9'($urandom);
          end
        if ($urandom_range(0, 30) == 0) grpMode = 2'($urandom_range(0, 3));
      end
      step("R3 R4 R5 R6 R8");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule